// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns an address into a real address by walking a tree of page directories held in memory. A request gives the address to translate, the base of the root directory, the number of index bits used at the root and the total size of the address space in bits. The walker reads one 64-bit entry at a time over a simple request/response memory port. Each fetched directory entry names the next directory and how many index bits that directory uses. The walk continues until a leaf entry is found.

When the walk ends at a leaf, the walker reports the leaf entry, the page size (the address bits still left untranslated) and the real address. A walk can also end in a fault. One fault cause marks an entry whose valid bit is clear. The other marks a tree shape the walker does not support. Before any table is used, the low bits of its base are cleared to the table's natural alignment, and no error is raised for this.

Entry format: bit 63 is the valid flag and bit 62 is the leaf flag. In a directory entry, bits [55:8] hold the next directory base and bits [4:0] hold the next index-bit count. In a leaf entry, bits [55:12] hold the page number.

Top module: `radix_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `mem_req`, `done` and `fault` are all low.
- R2: Each fetch is made at `base + 8*idx`. Here `idx` is the address shifted right by (remaining size − index bits) and masked to the index-bit count. So every fetch address is a multiple of 8.
- R3: Before a base (root or next) is used, its low (index bits + 3) bits are cleared.
- R4: Before each fetch, the walker checks the level. Level 0 needs total size 52 and 13 index bits. Levels 1 and 2 need 9 index bits. Level 3 needs 9 or 5. Any other level fails. A failure raises `fault` with `cause_badcfg` set and `cause_noent` clear, and that level issues no fetch.
- R5: A fetched entry with bit 63 clear ends the walk. It raises `fault` with `cause_noent` set and `cause_badcfg` clear.
- R6: After each valid fetch, the remaining size drops by the current index-bit count. At a leaf, `page_bits` reports the remaining size.
- R7: A valid entry with bit 62 clear is a directory entry. Bits [55:8] give the next base and bits [4:0] give the next index-bit count, and the walk then moves one level down.
- R8: A valid entry with bit 62 set ends the walk with a one-cycle `done` pulse. `leaf_entry` holds the entry. `real_addr` takes page-number bits [55:12] at and above the remaining size, and address bits below it.
- R9: At most one read is outstanding at a time. `mem_req` is a one-cycle pulse, and it is not raised again until the response has arrived.
- R10: `done` or `fault` is a one-cycle pulse. It is given in the cycle the walker is already idle again, so a `start` in that same cycle is accepted. A `start` that arrives while a walk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| va | input | 64 | Address to translate |
| root_base | input | 56 | Root directory base |
| root_bits | input | 5 | Root index-bit count |
| total_size | input | 7 | Address-space size in bits |
| mem_req | output | 1 | Entry read request pulse |
| mem_addr | output | 56 | Entry read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Successful completion pulse |
| fault | output | 1 | Fault completion pulse |
| cause_noent | output | 1 | Fault cause: invalid entry |
| cause_badcfg | output | 1 | Fault cause: unsupported tree shape |
| leaf_entry | output | 64 | Leaf entry of the last successful walk |
| page_bits | output | 7 | Page size in address bits |
| real_addr | output | 56 | Translated real address |

## Verification
Two things can happen in the same cycle: a walk completing and the next request being accepted. `done` or `fault` is raised in the first idle cycle, so a `start` in that cycle must begin a new walk. The bench waits for a completion pulse and drives the next request in that same cycle. It then checks that the second walk's fetch addresses and result match the reference model. The opposite case, a `start` that arrives while a walk is in progress, is also driven, and the bench checks that it changes neither the fetch stream nor the result.

// File: rtl/radix_walker.sv
module radix_walker #(
  parameter int AW       = 56,
  parameter int EW       = 64,
  parameter int IW       = 5,
  parameter int SW       = 7,
  parameter int TOP_SIZE = 52,
  parameter int TOP_BITS = 13,
  parameter int MID_BITS = 9,
  parameter int ALT_BITS = 5,
  parameter int LAST_LVL = 3,
  parameter int PN_LSB   = 12,
  parameter int NB_LSB   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [EW-1:0] va,
  input  logic [AW-1:0] root_base,
  input  logic [IW-1:0] root_bits,
  input  logic [SW-1:0] total_size,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rsp_valid,
  input  logic [EW-1:0] mem_rsp_data,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic          cause_noent,
  output logic          cause_badcfg,
  output logic [EW-1:0] leaf_entry,
  output logic [SW-1:0] page_bits,
  output logic [AW-1:0] real_addr
);
  localparam int LW = $clog2(LAST_LVL + 2);
  localparam int VB = EW - 1;
  localparam int LB = EW - 2;

  typedef enum logic [1:0] {S_IDLE, S_CHK, S_WAIT} st_t;
  st_t st;

  logic [EW-1:0] va_q;
  logic [AW-1:0] base_q;
  logic [IW-1:0] bits_q;
  logic [SW-1:0] rem_q;
  logic [LW-1:0] lvl_q;
  logic          lvl_ok;

  function automatic logic [AW-1:0] align(input logic [AW-1:0] b, input logic [IW-1:0] n);
    return b & ({AW{1'b1}} << (int'(n) + 3));
  endfunction

  always_comb begin
    if (lvl_q == '0)
      lvl_ok = (rem_q == SW'(TOP_SIZE)) && (bits_q == IW'(TOP_BITS));
    else if (int'(lvl_q) < LAST_LVL)
      lvl_ok = bits_q == IW'(MID_BITS);
    else if (int'(lvl_q) == LAST_LVL)
      lvl_ok = (bits_q == IW'(MID_BITS)) || (bits_q == IW'(ALT_BITS));
    else
      lvl_ok = 1'b0;
  end

  logic [SW-1:0] sh, rem_n;
  logic [EW-1:0] idx;
  logic [AW-1:0] pmask, rpn, nbase;

  assign sh       = rem_q - SW'(bits_q);
  assign idx      = (va_q >> sh) & ~({EW{1'b1}} << bits_q);
  assign mem_addr = base_q + {idx[AW-4:0], 3'b000};
  assign mem_req  = (st == S_CHK) && lvl_ok;
  assign busy     = st != S_IDLE;
  assign rem_n    = rem_q - SW'(bits_q);
  assign pmask    = ~({AW{1'b1}} << rem_n);
  assign rpn      = {mem_rsp_data[AW-1:PN_LSB], {PN_LSB{1'b0}}};
  assign nbase    = {mem_rsp_data[AW-1:NB_LSB], {NB_LSB{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      va_q         <= '0;
      base_q       <= '0;
      bits_q       <= '0;
      rem_q        <= '0;
      lvl_q        <= '0;
      done         <= 1'b0;
      fault        <= 1'b0;
      cause_noent  <= 1'b0;
      cause_badcfg <= 1'b0;
      leaf_entry   <= '0;
      page_bits    <= '0;
      real_addr    <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          va_q         <= va;
          base_q       <= align(root_base, root_bits);
          bits_q       <= root_bits;
          rem_q        <= total_size;
          lvl_q        <= '0;
          cause_noent  <= 1'b0;
          cause_badcfg <= 1'b0;
          st           <= S_CHK;
        end
        S_CHK: if (!lvl_ok) begin
          fault        <= 1'b1;
          cause_badcfg <= 1'b1;
          st           <= S_IDLE;
        end else begin
          st <= S_WAIT;
        end
        S_WAIT: if (mem_rsp_valid) begin
          if (!mem_rsp_data[VB]) begin
            fault       <= 1'b1;
            cause_noent <= 1'b1;
            st          <= S_IDLE;
          end else if (mem_rsp_data[LB]) begin
            done       <= 1'b1;
            leaf_entry <= mem_rsp_data;
            page_bits  <= rem_n;
            real_addr  <= (rpn & ~pmask) | (va_q[AW-1:0] & pmask);
            st         <= S_IDLE;
          end else begin
            bits_q <= mem_rsp_data[IW-1:0];
            base_q <= align(nbase, mem_rsp_data[IW-1:0]);
            rem_q  <= rem_n;
            lvl_q  <= lvl_q + 1'b1;
            st     <= S_CHK;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic [55:0] mem_addr,
  input logic        busy,
  input logic        done,
  input logic        fault,
  input logic        cause_noent,
  input logic        cause_badcfg,
  input logic [63:0] leaf_entry,
  input logic [6:0]  page_bits
);
  AST_REQ_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> !mem_req); // R9
  AST_REQ_BUSY:     assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> busy); // R9
  AST_REQ_ALIGNED:  assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> mem_addr[2:0] == 3'b000); // R2
  AST_END_EXCL:     assert property (@(posedge clk) disable iff (!rst_n) !(done && fault)); // R10
  AST_END_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) (done || fault) |-> (!busy && !mem_req)); // R10
  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) fault |-> $onehot({cause_noent, cause_badcfg})); // R4
  AST_LEAF_FLAGS:   assert property (@(posedge clk) disable iff (!rst_n) done |-> (leaf_entry[63] && leaf_entry[62])); // R8
  AST_PAGE_RANGE:   assert property (@(posedge clk) disable iff (!rst_n) done |-> (page_bits < 7'd52)); // R6
endmodule

bind radix_walker radix_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr), .busy(busy),
  .done(done), .fault(fault), .cause_noent(cause_noent), .cause_badcfg(cause_badcfg),
  .leaf_entry(leaf_entry), .page_bits(page_bits)
);

// File: tb/tb_radix_walker.sv
module tb_radix_walker;
  logic        clk = 0, rst_n = 0, start = 0;
  logic [63:0] va = '0;
  logic [55:0] root_base = '0;
  logic [4:0]  root_bits = '0;
  logic [6:0]  total_size = '0;
  logic        mem_req, mem_rsp_valid = 0;
  logic [55:0] mem_addr;
  logic [63:0] mem_rsp_data = '0;
  logic        busy, done, fault, cause_noent, cause_badcfg;
  logic [63:0] leaf_entry;
  logic [6:0]  page_bits;
  logic [55:0] real_addr;

  radix_walker dut (
    .clk(clk), .rst_n(rst_n), .start(start), .va(va), .root_base(root_base),
    .root_bits(root_bits), .total_size(total_size), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .busy(busy), .done(done),
    .fault(fault), .cause_noent(cause_noent), .cause_badcfg(cause_badcfg),
    .leaf_entry(leaf_entry), .page_bits(page_bits), .real_addr(real_addr)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, lat = 1, pcnt = 0;
  bit pend = 0, outstanding = 0, exp_busy = 0;
  logic [55:0] paddr, a;
  logic [63:0] mem [logic [55:0]];
  logic [55:0] exp_q [$];
  int exp_kind, exp_page;
  logic [63:0] exp_entry;
  logic [55:0] exp_raddr;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [55:0] ad);
    return mem.exists(ad) ? mem[ad] : 64'h0;
  endfunction

  function automatic logic [55:0] slot(input logic [55:0] b, input logic [63:0] v, input int rem, input int bits);
    logic [63:0] ix = (v >> (rem - bits)) & ((64'h1 << bits) - 1);
    return b + ix[52:0] * 8;
  endfunction

  task automatic model(input logic [63:0] v, input logic [55:0] rb, input int b0, input int sz);
    logic [63:0] base, e, ix, m;
    int rem = sz, b = b0, lvl = 0;
    bit ok;
    base = {8'h0, rb} & ~((64'h1 << (b + 3)) - 1);
    while (1) begin
      case (lvl)
        0: ok = (rem == 52) && (b == 13);
        1, 2: ok = (b == 9);
        3: ok = (b == 9) || (b == 5);
        default: ok = 0;
      endcase
      if (!ok) begin exp_kind = 2; return; end
      ix = (v >> (rem - b)) & ((64'h1 << b) - 1);
      exp_q.push_back(base[55:0] + ix[55:0] * 8);
      e = rd(base[55:0] + ix[55:0] * 8);
      if (!e[63]) begin exp_kind = 1; return; end
      rem = rem - b;
      if (e[62]) begin
        m = (64'h1 << rem) - 1;
        exp_kind = 0; exp_entry = e; exp_page = rem;
        exp_raddr = (((e & 64'h00FF_FFFF_FFFF_F000) & ~m) | (v & m)) & 64'h00FF_FFFF_FFFF_FFFF;
        return;
      end
      b = int'(e[4:0]);
      base = (e & 64'h00FF_FFFF_FFFF_FF00) & ~((64'h1 << (b + 3)) - 1);
      lvl++;
    end
  endtask

  task automatic build(input logic [63:0] v, input logic [55:0] rb, input int n, input int b1,
                       input int b3, input bit mis, input logic [55:0] rpn);
    logic [55:0] base = rb, nb;
    int rem = 52, bits = 13, nbits;
    for (int i = 0; i < n; i++) begin
      nb = rb + 56'h100000 * (i + 1);
      nbits = (i == 0) ? b1 : ((i == 2) ? b3 : 9);
      mem[slot(base, v, rem, bits)] = {2'b10, 6'h0, nb | (mis ? 56'h300 : 56'h0)} | 64'(nbits);
      base = nb; rem -= bits; bits = nbits;
    end
    mem[slot(base, v, rem, bits)] = {2'b11, 6'h0, rpn & ~56'hFFF};
  endtask

  task automatic launch(input logic [63:0] v, input logic [55:0] rb, input int b, input int sz);
    model(v, rb, b, sz);
    exp_busy = 1;
    va = v; root_base = rb; root_bits = 5'(b); total_size = 7'(sz); start = 1;
    @(negedge clk); #1 start = 0;
  endtask

  task automatic finish_wait();
    while (exp_busy) @(negedge clk);
    #1;
  endtask

  task automatic walk(input logic [63:0] v, input logic [55:0] rb, input int b, input int sz, input int l);
    lat = l;
    @(negedge clk); #1;
    launch(v, rb, b, sz);
    finish_wait();
  endtask

  // Reference comparison, every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req) begin
        chk(!outstanding, "R9 single outstanding read", 64'(outstanding), 0);
        if (exp_q.size() == 0) chk(0, "R4 R9 unexpected fetch", 64'(mem_addr), 0);
        else begin
          a = exp_q.pop_front();
          chk(mem_addr == a, "R2 R3 entry address", 64'(mem_addr), 64'(a));
        end
      end
      if (done || fault) begin
        chk(exp_busy, "R10 unexpected completion", 64'({done, fault}), 0);
        if (exp_kind == 0) begin
          chk(done && !fault, "R8 leaf completion", 64'({done, fault}), 64'h2);
          chk(real_addr == exp_raddr, "R8 real address", 64'(real_addr), 64'(exp_raddr));
          chk(page_bits == 7'(exp_page), "R6 page size", 64'(page_bits), 64'(exp_page));
          chk(leaf_entry == exp_entry, "R7 R8 leaf entry", leaf_entry, exp_entry);
        end else if (exp_kind == 1)
          chk(fault && cause_noent && !cause_badcfg, "R5 no-entry fault", 64'({fault, cause_noent, cause_badcfg}), 64'h6);
        else
          chk(fault && cause_badcfg && !cause_noent, "R4 bad-config fault", 64'({fault, cause_noent, cause_badcfg}), 64'h5);
        chk(exp_q.size() == 0, "R4 R9 fetch count", 64'(exp_q.size()), 0);
        exp_busy = 0;
      end
      mem_rsp_valid = 0;
      if (pend) begin
        if (pcnt == 0) begin
          mem_rsp_valid = 1; mem_rsp_data = rd(paddr); pend = 0; outstanding = 0;
        end else pcnt--;
      end
      if (mem_req) begin pend = 1; outstanding = 1; pcnt = lat - 1; paddr = mem_addr; end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R10 watchdog expired actual=busy expected=idle");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !mem_req && !done && !fault, "R1 reset state", 64'({busy, mem_req, done, fault}), 0);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!busy && !mem_req, "R1 idle after reset", 64'({busy, mem_req}), 0);

    // R2 R6 R7 R8: four-level walk, 5-bit last level
    build(64'h000A_BCDE_F123_4567, 56'h0100_0000, 3, 9, 5, 0, 56'h12_3456_789A_B000);
    walk(64'h000A_BCDE_F123_4567, 56'h0100_0000, 13, 52, 1);
    // R6 R8: leaf at level 2
    build(64'h0007_6543_2109_8765, 56'h0200_0000, 2, 9, 9, 0, 56'h00_ABCD_EF01_2000);
    walk(64'h0007_6543_2109_8765, 56'h0200_0000, 13, 52, 2);
    // R3: misaligned root base, leaf at level 1
    build(64'h0003_3333_5555_7777, 56'h0300_0000, 1, 9, 9, 0, 56'h7F_0000_1234_5000);
    walk(64'h0003_3333_5555_7777, 56'h0300_1238, 13, 52, 3);
    // R3 R7: misaligned next bases, 9-bit last level
    build(64'h000F_0F0F_0F0F_0F0F, 56'h0400_0000, 3, 9, 9, 1, 56'h55_AAAA_5555_A000);
    walk(64'h000F_0F0F_0F0F_0F0F, 56'h0400_0000, 13, 52, 1);
    // R5: invalid root entry
    walk(64'h0001_2222_3333_4444, 56'h0500_0000, 13, 52, 2);
    // R5: invalid entry at level 2
    build(64'h0009_8888_7777_6666, 56'h0600_0000, 3, 9, 5, 0, 56'h01_0000_0000_0000);
    mem.delete(slot(56'h0620_0000, 64'h0009_8888_7777_6666, 30, 9));
    walk(64'h0009_8888_7777_6666, 56'h0600_0000, 13, 52, 1);
    // R4: bad total size, bad root bits (no fetch)
    walk(64'h0000_1111_2222_3333, 56'h0100_0000, 13, 48, 1);
    walk(64'h0000_1111_2222_3333, 56'h0100_0000, 12, 52, 1);
    // R4: level 1 index bits 8, level 3 index bits 7, non-leaf at level 3
    build(64'h0004_4444_4444_4444, 56'h0700_0000, 3, 8, 5, 0, 56'h0);
    walk(64'h0004_4444_4444_4444, 56'h0700_0000, 13, 52, 1);
    build(64'h0005_5555_5555_5555, 56'h0800_0000, 3, 9, 7, 0, 56'h0);
    walk(64'h0005_5555_5555_5555, 56'h0800_0000, 13, 52, 2);
    build(64'h0006_6666_6666_6666, 56'h0900_0000, 4, 9, 9, 0, 56'h0);
    walk(64'h0006_6666_6666_6666, 56'h0900_0000, 13, 52, 1);

    // R10: start while busy is ignored
    build(64'h0002_4680_1357_9BDF, 56'h0A00_0000, 3, 9, 5, 0, 56'h33_4444_5555_6000);
    lat = 3;
    @(negedge clk); #1;
    launch(64'h0002_4680_1357_9BDF, 56'h0A00_0000, 13, 52);
    @(negedge clk); #1;
    va = 64'h0001_2222_3333_4444; root_base = 56'h0500_0000; start = 1;
    @(negedge clk); #1 start = 0;
    @(negedge clk); #1 start = 1;
    @(negedge clk); #1 start = 0;
    finish_wait();

    // R10: completion and next start in the same cycle
    build(64'h0008_1234_8765_4321, 56'h0B00_0000, 2, 9, 9, 0, 56'h44_0000_0000_0000);
    build(64'h000C_CCCC_DDDD_EEEE, 56'h0C00_0000, 3, 9, 5, 0, 56'h66_7777_8888_9000);
    lat = 1;
    @(negedge clk); #1;
    launch(64'h0008_1234_8765_4321, 56'h0B00_0000, 13, 52);
    do begin @(negedge clk); #1; end while (!(done || fault));
    launch(64'h000C_CCCC_DDDD_EEEE, 56'h0C00_0000, 13, 52);
    finish_wait();
    chk(!busy, "R10 idle after back-to-back walks", 64'(busy), 0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule